// File: doc/BRIEF.md
# Supply-Aware Transmit Gating Controller

This controller sits between a packet modulator and the enable of the transmit amplifier. While a packet is on the line it watches three supply-status flags from analog comparators: one says the supply has sagged below a lower threshold, one says it sits above a higher threshold, and one says the stored energy is too small to carry a whole packet. A sag below the lower threshold does not abort the packet. The controller switches the amplifier off and holds the modulator on its current bit. Only when the supply is back above the higher threshold does it re-enable the amplifier and release the modulator. The gap between the two thresholds gives hysteresis, so the output does not chatter around a single trip point.

Every comparator flag passes through a two-stage synchronizer and then a persistence filter before the controller acts on it. The energy flag only gates the start of a new packet. A pause that lasts longer than a programmable number of clocks cancels the packet and raises a one-clock error pulse. After a cancel the controller waits until the request has been withdrawn before it accepts a new packet.

Top module: `txgate_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, amp_en, mod_stall, tx_active and pause_err are all 0.
- R2: With the controller idle and the filtered energy flag clear, tx_req high at a clock edge starts a packet. From that edge on, amp_en=1, tx_active=1 and mod_stall=0.
- R3: While the filtered energy flag is 1, a new packet does not start and tx_active stays 0. The flag has no effect on a packet that has already started. Once the flag clears, a held request starts the packet at the edge after the filter releases it (7 clocks after the raw input changes).
- R4: Each flag is synchronized by two flip-flops and takes effect only after the synchronized value has differed from the filtered value for 4 consecutive clocks. A pulse shorter than 4 clocks is ignored. A sag that persists turns amp_en off 7 clocks after the raw input rises.
- R5: In a packet, a filtered below-lower flag pauses it. amp_en goes to 0 and mod_stall goes to 1, while tx_active stays 1.
- R6: A paused packet resumes only on the filtered above-higher flag. Clearing the below-lower flag alone does not resume it. On resume, amp_en returns to 1 for one clock with mod_stall still 1, and then mod_stall falls.
- R7: tx_req going low ends the packet, whether it is running or paused. tx_active and amp_en are 0 from the next edge, and pause_err stays 0.
- R8: When pause_limit = N > 0, a packet paused for N consecutive clocks is cancelled. tx_active falls and pause_err pulses. The controller then starts no new packet until tx_req has been low. pause_limit = 0 disables the timeout.
- R9: pause_err is a single-clock pulse and only follows a paused state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Modulator holds high for the duration of a packet |
| sup_below_lo | input | 1 | Comparator: supply below lower threshold (asynchronous) |
| sup_above_hi | input | 1 | Comparator: supply above upper threshold (asynchronous) |
| energy_short | input | 1 | Comparator: stored energy too small for a packet (asynchronous) |
| pause_limit | input | TMO_W | Pause timeout in clocks; 0 disables |
| amp_en | output | 1 | Transmit amplifier enable |
| mod_stall | output | 1 | Holds the modulator at its current bit |
| tx_active | output | 1 | High for the whole packet, including pauses |
| pause_err | output | 1 | One-clock pulse when a pause times out |

## Verification
A fault in the flag filter shows up at the ports as a wrong delay from a flag edge to the change on amp_en. It can also show up as a short glitch that pauses the amplifier when it should not. Both are measured to the clock with sweeps of pulse length. A fault in the state machine shows up within one clock as amp_en and mod_stall out of step: a pause that never resumes, a resume that skips the one-clock stall, or tx_active falling during a pause. A fault in the timer shows up as a stall window that differs from pause_limit. A sweep of limits exposes it, and the same sweep checks that the error pulse lasts one clock and that the controller is not re-armed after a cancel.

// File: rtl/txg_pkg.sv
package txg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_TX     = 2'd1,
      ST_PAUSED = 2'd2,
      ST_RESUME = 2'd3
   } txg_state_e;

   localparam int unsigned FLAG_LO  = 0;
   localparam int unsigned FLAG_HI  = 1;
   localparam int unsigned FLAG_EN  = 2;
   localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/txg_flag_filter.sv
module txg_flag_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 4,
   parameter bit          RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);
   localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("txg_flag_filter: SYNC_STAGES must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("txg_flag_filter: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   generate
      if (HOLD_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt <= RST_VAL;
            else        filt <= sync_out;
         end
      end else begin : g_persist
         logic [CNT_W-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt    <= RST_VAL;
               run_cnt <= '0;
            end else if (sync_out == filt) begin
               run_cnt <= '0;
            end else if (run_cnt == CNT_W'(HOLD_CYCLES - 1)) begin
               filt    <= sync_out;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/txg_pause_timer.sv
module txg_pause_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   generate
      if (TMO_W < 1) begin : g_bad_w
         $error("txg_pause_timer: TMO_W must be at least 1");
      end
   endgenerate

   logic [TMO_W-1:0] cnt_q;
   logic             at_max;

   assign at_max = (cnt_q == {TMO_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!at_max) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (limit != '0) && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/txg_fsm.sv
module txg_fsm
   import txg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_req,
   input  logic lo_f,
   input  logic hi_f,
   input  logic en_f,
   input  logic expired,
   output logic pausing,
   output logic amp_en,
   output logic mod_stall,
   output logic tx_active,
   output logic pause_err
);
   txg_state_e state_q, state_d;
   logic       armed_q;
   logic       cancel_tmo;

   assign cancel_tmo = (state_q == ST_PAUSED) && tx_req && expired;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (tx_req && armed_q && !en_f) state_d = ST_TX;
         ST_TX: begin
            if (!tx_req)   state_d = ST_IDLE;
            else if (lo_f) state_d = ST_PAUSED;
         end
         ST_PAUSED: begin
            if (!tx_req || expired) state_d = ST_IDLE;
            else if (hi_f)          state_d = ST_RESUME;
         end
         ST_RESUME: state_d = tx_req ? ST_TX : ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         armed_q   <= 1'b1;
         pause_err <= 1'b0;
      end else begin
         state_q   <= state_d;
         pause_err <= cancel_tmo;
         if (!tx_req)         armed_q <= 1'b1;
         else if (cancel_tmo) armed_q <= 1'b0;
      end
   end

   assign pausing   = (state_q == ST_PAUSED);
   assign amp_en    = (state_q == ST_TX) || (state_q == ST_RESUME);
   assign mod_stall = (state_q == ST_PAUSED) || (state_q == ST_RESUME);
   assign tx_active = (state_q != ST_IDLE);
endmodule

// File: rtl/txgate_ctrl.sv
module txgate_ctrl
   import txg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 4,
   parameter int unsigned TMO_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_req,
   input  logic             sup_below_lo,
   input  logic             sup_above_hi,
   input  logic             energy_short,
   input  logic [TMO_W-1:0] pause_limit,
   output logic             amp_en,
   output logic             mod_stall,
   output logic             tx_active,
   output logic             pause_err
);
   logic [NUM_FLAGS-1:0] raw_flags;
   logic [NUM_FLAGS-1:0] filt_flags;
   logic                 lo_filt, hi_filt, en_filt;
   logic                 pausing, expired;

   assign raw_flags[FLAG_LO] = sup_below_lo;
   assign raw_flags[FLAG_HI] = sup_above_hi;
   assign raw_flags[FLAG_EN] = energy_short;

   generate
      for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         txg_flag_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_CYCLES (HOLD_CYCLES),
            .RST_VAL     (1'b0)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flags[gi]),
            .filt (filt_flags[gi])
         );
      end
   endgenerate

   assign lo_filt = filt_flags[FLAG_LO];
   assign hi_filt = filt_flags[FLAG_HI];
   assign en_filt = filt_flags[FLAG_EN];

   txg_pause_timer #(.TMO_W(TMO_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (pausing),
      .limit  (pause_limit),
      .expired(expired)
   );

   txg_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_req   (tx_req),
      .lo_f     (lo_filt),
      .hi_f     (hi_filt),
      .en_f     (en_filt),
      .expired  (expired),
      .pausing  (pausing),
      .amp_en   (amp_en),
      .mod_stall(mod_stall),
      .tx_active(tx_active),
      .pause_err(pause_err)
   );
endmodule

// File: rtl/txg_checker.sv
module txg_checker (
   input logic clk,
   input logic rst_n,
   input logic lo_f,
   input logic hi_f,
   input logic en_f,
   input logic amp_en,
   input logic mod_stall,
   input logic tx_active,
   input logic pause_err
);
   AST_AMP_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      amp_en |-> tx_active); // R5
   AST_STALL_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      mod_stall |-> tx_active); // R5
   AST_START_NEEDS_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_active) |-> !$past(en_f)); // R3
   AST_PAUSE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && $fell(amp_en)) |-> $past(lo_f)); // R5
   AST_RESUME_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mod_stall && !amp_en) && amp_en) |-> ($past(hi_f) && mod_stall)); // R6
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pause_err |=> !pause_err); // R9
   AST_ERR_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      pause_err |-> (!tx_active && $past(mod_stall && !amp_en))); // R8
endmodule

bind txgate_ctrl txg_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lo_f     (lo_filt),
   .hi_f     (hi_filt),
   .en_f     (en_filt),
   .amp_en   (amp_en),
   .mod_stall(mod_stall),
   .tx_active(tx_active),
   .pause_err(pause_err)
);

// File: tb/tb_txgate_ctrl.sv
module tb_txgate_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int TMO_W      = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_req = 1'b0;
   logic             sup_below_lo = 1'b0;
   logic             sup_above_hi = 1'b1;
   logic             energy_short = 1'b0;
   logic [TMO_W-1:0] pause_limit = '0;
   logic             amp_en, mod_stall, tx_active, pause_err;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txgate_ctrl #(.SYNC_STAGES(2), .HOLD_CYCLES(4), .TMO_W(TMO_W)) dut (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req),
      .sup_below_lo(sup_below_lo), .sup_above_hi(sup_above_hi),
      .energy_short(energy_short), .pause_limit(pause_limit),
      .amp_en(amp_en), .mod_stall(mod_stall), .tx_active(tx_active),
      .pause_err(pause_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int outs();
      return {28'd0, amp_en, mod_stall, tx_active, pause_err};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int cnt_lo, cnt_st, cnt_err, lat;
      // R1 reset state
      step(3);
      check(outs() == 0, "R1 outputs in reset", outs(), 0);
      rst_n = 1'b1;
      step(1);
      check(outs() == 0, "R1 outputs after reset", outs(), 0);
      step(10);

      // R2 start
      tx_req = 1'b1;
      step(1);
      check(outs() == 4'b1010, "R2 start outputs", outs(), 4'b1010);

      // R4 glitch sweep with R5/R6 pause-resume lengths
      for (int len = 1; len <= 6; len++) begin
         sup_below_lo = 1'b1; sup_above_hi = 1'b0;
         cnt_lo = 0; cnt_st = 0;
         for (int k = 0; k < 25; k++) begin
            if (k == len) begin sup_below_lo = 1'b0; sup_above_hi = 1'b1; end
            step(1);
            if (!amp_en) cnt_lo++;
            if (mod_stall) cnt_st++;
            if (!tx_active) cnt_lo += 100;
         end
         check(cnt_lo == ((len >= 4) ? len : 0), "R4 glitch amp_en low cycles", cnt_lo, (len >= 4) ? len : 0);
         check(cnt_st == ((len >= 4) ? len + 1 : 0), "R6 stall cycles incl resume", cnt_st, (len >= 4) ? len + 1 : 0);
      end

      // R4 latency, R5 pause outputs
      sup_below_lo = 1'b1; sup_above_hi = 1'b0;
      lat = 0;
      for (int k = 1; k <= 12; k++) begin
         step(1);
         if (lat == 0 && !amp_en) lat = k;
      end
      check(lat == 7, "R4 sag latency", lat, 7);
      check(outs() == 4'b0110, "R5 paused outputs", outs(), 4'b0110);

      // R6 clearing low alone does not resume
      sup_below_lo = 1'b0;
      step(15);
      check(outs() == 4'b0110, "R6 no resume without high flag", outs(), 4'b0110);
      sup_above_hi = 1'b1;
      lat = 0;
      for (int k = 1; k <= 7; k++) begin
         step(1);
         if (lat == 0 && amp_en) lat = k;
      end
      check(lat == 7, "R6 resume latency", lat, 7);
      check(mod_stall == 1'b1, "R6 stall held during resume cycle", mod_stall, 1);
      step(1);
      check(outs() == 4'b1010, "R6 back in transmit", outs(), 4'b1010);

      // R7 completion
      tx_req = 1'b0;
      step(1);
      check(outs() == 0, "R7 complete", outs(), 0);

      // R3 energy gating
      energy_short = 1'b1;
      step(10);
      tx_req = 1'b1;
      cnt_lo = 0;
      for (int k = 0; k < 10; k++) begin step(1); if (tx_active) cnt_lo++; end
      check(cnt_lo == 0, "R3 blocked start", cnt_lo, 0);
      energy_short = 1'b0;
      step(6);
      check(tx_active == 1'b0, "R3 still idle before filter release", tx_active, 0);
      step(1);
      check(tx_active == 1'b1, "R3 start after release", tx_active, 1);
      energy_short = 1'b1;
      step(12);
      check(amp_en == 1'b1, "R3 no effect mid-packet", amp_en, 1);
      energy_short = 1'b0;
      step(8);

      // R7 cancel while paused
      sup_below_lo = 1'b1; sup_above_hi = 1'b0;
      step(9);
      check(mod_stall == 1'b1, "R7 paused before cancel", mod_stall, 1);
      tx_req = 1'b0;
      cnt_err = 0;
      step(1);
      check(outs() == 0, "R7 cancel outputs", outs(), 0);
      for (int k = 0; k < 5; k++) begin step(1); if (pause_err) cnt_err++; end
      check(cnt_err == 0, "R7 no error on cancel", cnt_err, 0);
      sup_below_lo = 1'b0; sup_above_hi = 1'b1;
      step(8);

      // R8/R9 timeout sweep
      for (int lim = 1; lim <= 6; lim++) begin
         pause_limit = TMO_W'(lim);
         tx_req = 1'b1;
         step(2);
         sup_below_lo = 1'b1; sup_above_hi = 1'b0;
         cnt_st = 0; cnt_err = 0;
         for (int k = 0; k < 30; k++) begin
            step(1);
            if (mod_stall) cnt_st++;
            if (pause_err) cnt_err++;
         end
         check(cnt_st == lim, "R8 pause window", cnt_st, lim);
         check(cnt_err == 1, "R9 error pulse width", cnt_err, 1);
         check(tx_active == 1'b0, "R8 no restart while request held", tx_active, 0);
         tx_req = 1'b0;
         sup_below_lo = 1'b0; sup_above_hi = 1'b1;
         step(9);
         tx_req = 1'b1;
         step(1);
         check(tx_active == 1'b1, "R8 rearmed after request low", tx_active, 1);
         tx_req = 1'b0;
         step(2);
      end

      // R8 limit 0 disables timeout
      pause_limit = '0;
      tx_req = 1'b1;
      step(2);
      sup_below_lo = 1'b1; sup_above_hi = 1'b0;
      step(300);
      check(outs() == 4'b0110, "R8 zero limit keeps pause", outs(), 4'b0110);
      tx_req = 1'b0;
      step(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule